// File: doc/BRIEF.md
# Run-Length Capture Channel with Clean Halt

One logic-analyzer channel receives one-bit samples qualified by a valid strobe and compresses them into run records. Each record carries the level of a run and the number of valid samples it lasted. Records go out with a write strobe to a per-channel FIFO, which absorbs bursts of data that compresses badly. A signal that toggles on nearly every sample gives one record per sample, so the encoded data can be larger than the raw data. This expansion is accepted.

The FIFO can fill up. When a record is due and the FIFO reports no room, the channel stops capturing rather than lose samples. The unfinished run is held and written as the last record once the FIFO has room. After that the channel stays stopped. Every record written before the stop describes the input exactly. Pulsing `arm` starts a new capture from an empty run.

Top module: `rl_capture_chan`

## Requirements
- R1: After reset `halted` and `rec_we` are 0. Until `arm` is pulsed, samples produce no records.
- R2: When a valid sample differs in level from the current run, the finished run is written as one record. `rec_level` holds the run level and `rec_count` holds the number of valid samples in the run. `rec_we` is high for exactly the one cycle after the clock edge that took the differing sample.
- R3: A run starts at a count of one. A sample stream that toggles on every valid sample gives one record of count 1 per sample.
- R4: A run can count up to 2^CNT_W-1 samples (4095 by default). The next equal sample writes that full run as a record and starts a new run of the same level with a count of 1.
- R5: A cycle with `smp_valid` low neither extends nor ends a run.
- R6: A record can only be written if `fifo_ready` is high. `fifo_ready` low while no record is due has no effect. A record that is due while `fifo_ready` is low stops the capture: `halted` rises in the next cycle, nothing is written, and the sample that ended the run is discarded.
- R7: After the stop, the pending run is written exactly once. This happens in the cycle after the first edge at which `fifo_ready` is high. No record follows it.
- R8: Once set, `halted` stays high and samples are ignored until `arm` is pulsed.
- R9: An `arm` pulse clears `halted`, discards any partial run and starts a new capture.
- R10: `rec_we` is never high unless `fifo_ready` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start or restart a capture (one-cycle pulse) |
| smp_valid | input | 1 | Qualifies `smp_bit` in this cycle |
| smp_bit | input | 1 | Channel sample |
| fifo_ready | input | 1 | FIFO can accept a record this cycle |
| rec_level | output | 1 | Level of the written run |
| rec_count | output | CNT_W | Length of the written run in samples |
| rec_we | output | 1 | FIFO write strobe |
| halted | output | 1 | Capture stopped on a full FIFO |

## Verification
The hardest cases to reach are the saturated run and the stop-then-flush sequence.

For the saturated run, the bench feeds 4096 equal valid samples. The maximum count is only reached after 4095 of them, and the 4096th must cut the run.

For the stop-then-flush sequence, the bench holds `fifo_ready` low at the exact edge where a level change needs a record. It keeps `fifo_ready` low for a few more cycles of changing samples, then raises it. The flushed record must show the held run's count with the dropped sample excluded, and nothing may follow it.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_HALT  = 2'd3
  } rlc_state_e;
endpackage

// File: rtl/rlc_run_tracker.sv
module rlc_run_tracker #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             smp_bit,
  output logic             need_emit,
  output logic             run_lvl,
  output logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             have_q, have_d;
  logic             lvl_d;
  logic [CNT_W-1:0] cnt_d;

  // A run closes on a level change or when its count is full.
  assign need_emit = have_q && ((smp_bit != run_lvl) || (run_cnt == CNT_MAX));

  always_comb begin
    have_d = have_q;
    lvl_d  = run_lvl;
    cnt_d  = run_cnt;
    if (clear) begin
      have_d = 1'b0;
      lvl_d  = 1'b0;
      cnt_d  = '0;
    end else if (take) begin
      if (!have_q || need_emit) begin
        have_d = 1'b1;
        lvl_d  = smp_bit;
        cnt_d  = CNT_ONE;
      end else begin
        cnt_d  = run_cnt + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      run_lvl <= 1'b0;
      run_cnt <= '0;
    end else if (clear || take) begin
      have_q  <= have_d;
      run_lvl <= lvl_d;
      run_cnt <= cnt_d;
    end
  end

  // R3: a run in progress never shows a zero count
  a_r3_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> (run_cnt != '0));
endmodule

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       smp_valid,
  input  logic       need_emit,
  input  logic       fifo_ready,
  output rlc_state_e state,
  output logic       take,
  output logic       clear,
  output logic       emit
);
  rlc_state_e state_d;

  always_comb begin
    state_d = state;
    take    = 1'b0;
    clear   = 1'b0;
    emit    = 1'b0;
    if (arm) begin
      state_d = ST_RUN;
      clear   = 1'b1;
    end else begin
      case (state)
        ST_RUN: begin
          if (smp_valid) begin
            if (need_emit && !fifo_ready) begin
              state_d = ST_FLUSH;
            end else begin
              take = 1'b1;
              emit = need_emit;
            end
          end
        end
        ST_FLUSH: begin
          if (fifo_ready) begin
            emit    = 1'b1;
            clear   = 1'b1;
            state_d = ST_HALT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R6: an emission always has FIFO room in the same cycle
  a_r6_emit_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> fifo_ready);
endmodule

// File: rtl/rl_capture_chan.sv
module rl_capture_chan
  import rlc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             smp_valid,
  input  logic             smp_bit,
  input  logic             fifo_ready,
  output logic             rec_level,
  output logic [CNT_W-1:0] rec_count,
  output logic             rec_we,
  output logic             halted
);
  rlc_state_e       state;
  logic             take, clear, emit, need_emit;
  logic             run_lvl;
  logic [CNT_W-1:0] run_cnt;

  rlc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .smp_valid (smp_valid),
    .need_emit (need_emit),
    .fifo_ready(fifo_ready),
    .state     (state),
    .take      (take),
    .clear     (clear),
    .emit      (emit)
  );

  rlc_run_tracker #(.CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .take     (take),
    .smp_bit  (smp_bit),
    .need_emit(need_emit),
    .run_lvl  (run_lvl),
    .run_cnt  (run_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_we <= 1'b0;
    else        rec_we <= emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_level <= 1'b0;
      rec_count <= '0;
    end else if (emit) begin
      rec_level <= run_lvl;
      rec_count <= run_cnt;
    end
  end

  assign halted = (state == ST_FLUSH) || (state == ST_HALT);

  // R10: no write without FIFO room one cycle earlier
  a_r10_we_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |-> $past(fifo_ready));
  // R2: a written record never carries a zero length
  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |-> (rec_count != '0));
  // R8: halted is sticky until arm
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !arm) |=> halted);
  // R7: the flush record is the last one
  a_r7_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && rec_we) |=> !rec_we);
endmodule

// File: tb/rl_capture_chan_bench.sv
module rl_capture_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int NVEC = 13;
  // {valid, bit, ready, exp_we, exp_level, exp_count[11:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'd3},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 12'd2},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'd1},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 12'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd0},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'd0},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'd3}
  };

  logic clk = 1'b0;
  logic rst_n, arm, smp_valid, smp_bit, fifo_ready;
  logic rec_level, rec_we, halted;
  logic [CNT_W-1:0] rec_count;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rl_capture_chan #(.CNT_W(CNT_W)) u_rl_capture_chan (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
    .smp_bit(smp_bit), .fifo_ready(fifo_ready), .rec_level(rec_level),
    .rec_count(rec_count), .rec_we(rec_we), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, sample at the next negedge
  task automatic step(input logic v, input logic b, input logic r);
    smp_valid = v; smp_bit = b; fifo_ready = r; arm = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1; smp_valid = 1'b0; fifo_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic chk_rec(input string req, input logic lvl, input int cnt);
    chk(rec_we == 1'b1, req, int'(rec_we), 1);
    chk(rec_level == lvl, req, int'(rec_level), int'(lvl));
    chk(int'(rec_count) == cnt, req, int'(rec_count), cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; smp_valid = 1'b0; smp_bit = 1'b0; fifo_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(halted == 1'b0, "R1 halted at reset", int'(halted), 0);
    chk(rec_we == 1'b0, "R1 we at reset", int'(rec_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: samples before arm are ignored
    begin
      bit any_we = 1'b0;
      for (int i = 0; i < 6; i++) begin
        step(1'b1, i[0], 1'b1);
        if (rec_we) any_we = 1'b1;
      end
      chk(!any_we, "R1 no records before arm", int'(any_we), 0);
    end

    // table: R2 R3 R5 and R6 (ready low without a due record)
    do_arm();
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][16], VEC[i][15], VEC[i][14]);
      if (VEC[i][13]) chk_rec("R2/R3 table record", VEC[i][12], int'(VEC[i][11:0]));
      else chk(rec_we == 1'b0, "R2/R5 table no record", int'(rec_we), 0);
      chk(halted == 1'b0, "R6 table no halt", int'(halted), 0);
    end

    // R4: saturation at 4095
    do_arm();
    begin
      bit any_we = 1'b0;
      for (int i = 0; i < 4095; i++) begin
        step(1'b1, 1'b1, 1'b1);
        if (rec_we) any_we = 1'b1;
      end
      chk(!any_we, "R4 no record before full", int'(any_we), 0);
    end
    step(1'b1, 1'b1, 1'b1);
    chk_rec("R4 full run", 1'b1, 4095);
    step(1'b1, 1'b0, 1'b1);
    chk_rec("R4 continued run", 1'b1, 1);

    // R6 R7 R8: stop on full FIFO, then flush
    do_arm();
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    chk(halted == 1'b0, "R6 ready low no due record", int'(halted), 0);
    step(1'b1, 1'b0, 1'b0);
    chk(halted == 1'b1, "R6 halt on full", int'(halted), 1);
    chk(rec_we == 1'b0, "R6 no write on full", int'(rec_we), 0);
    begin
      bit any_we = 1'b0;
      for (int i = 0; i < 3; i++) begin
        step(1'b1, i[0], 1'b0);
        if (rec_we) any_we = 1'b1;
      end
      chk(!any_we, "R7 no write while full", int'(any_we), 0);
    end
    step(1'b1, 1'b0, 1'b1);
    chk_rec("R7 flush record", 1'b1, 2);
    chk(halted == 1'b1, "R8 halted after flush", int'(halted), 1);
    begin
      bit any_we = 1'b0;
      bit low = 1'b0;
      for (int i = 0; i < 8; i++) begin
        step(1'b1, i[0], 1'b1);
        if (rec_we) any_we = 1'b1;
        if (!halted) low = 1'b1;
      end
      chk(!any_we, "R7 nothing after flush", int'(any_we), 0);
      chk(!low, "R8 halted sticky", int'(low), 0);
    end

    // R9: re-arm restarts
    do_arm();
    chk(halted == 1'b0, "R9 arm clears halt", int'(halted), 0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk_rec("R9 fresh run after arm", 1'b0, 2);
    // R9: arm discards a partial run
    step(1'b1, 1'b1, 1'b1);
    do_arm();
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk_rec("R9 partial run discarded", 1'b1, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule